// File: doc/BRIEF.md
# Pixel Block Range Clamping Stage

This block is the first registered stage of a fixed-ratio compressor for frame-memory traffic. Each accepted input is a 4x2 tile of eight 8-bit luma samples. The stage measures the tile's floor average and its spread, which is the largest sample minus the smallest. When the spread is small enough for the quarter of the 8-bit range that holds the average, every sample is pulled into that 64-value quarter. The two most significant bitplanes of the tile are then constant for the coding stages that follow. A tile whose spread is too wide for its quarter goes through untouched.

The clamped tile appears on the output one clock after it is accepted, together with a valid flag. A new tile may be presented on every cycle. Sample i of a tile occupies bits [8*i+7 : 8*i] of the 64-bit bus.

Top module: `quad_clamp_stage`

## Requirements
- R1: A tile presented with `validIn` high on a rising edge appears on `blkOut` after that edge, with `validOut` high. `validOut` is low after an edge at which `validIn` was low.
- R2: A synchronous active-high `rst` drives `validOut` low on the next edge.
- R3: The average is the floor of the 11-bit sum of the eight samples divided by 8. The spread is the maximum sample minus the minimum sample.
- R4: If the average is in 0..63 and the spread is below 32, every sample of 64 or more becomes 63.
- R5: If the average is in 64..127 and the spread is below 64, samples below 64 become 64 and samples of 128 or more become 127.
- R6: If the average is in 128..191 and the spread is below 64, samples below 128 become 128 and samples of 192 or more become 191.
- R7: If the average is in 192..255 and the spread is below 32, samples below 192 become 192.
- R8: A tile that meets none of the conditions in R4 to R7 is output unchanged. This includes a spread of exactly 32 in the outer quarters and a spread of exactly 64 in the inner quarters.
- R9: While `validIn` is low, `blkOut` keeps its previous value whatever `pixIn` carries.
- R10: Tiles on consecutive cycles are each accepted and output in order with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| validIn | input | 1 | Tile on `pixIn` is to be accepted |
| pixIn | input | 64 | Eight 8-bit samples, sample i at bits 8*i+7:8*i |
| validOut | output | 1 | `blkOut` holds a newly clamped tile |
| blkOut | output | 64 | Clamped tile, same packing as `pixIn` |

## Verification
The tiles used are built so that each quarter of the range gets one clamp from below or from above, or both, and each result shows which quarter was chosen. Spread values one below and exactly at the 32 and 64 limits separate a strict comparison from an inclusive one. Two tiles have sums of 511 and 512. They show whether the average is floored or rounded, because each choice picks a different quarter and gives a different output. Wide-spread tiles, a hold interval with changing input, and a reset during traffic complete the set.

// File: rtl/quad_clamp_pkg.sv
package quad_clamp_pkg;
  typedef enum logic [2:0] {
    BAND_LOW   = 3'd0,
    BAND_MIDLO = 3'd1,
    BAND_MIDHI = 3'd2,
    BAND_HIGH  = 3'd3,
    BAND_PASS  = 3'd4
  } bandSel_e;

  typedef struct packed {
    logic capture;
  } stageStrobe_t;
endpackage

// File: rtl/quad_clamp_ctrl.sv
module quad_clamp_ctrl
  import quad_clamp_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         validIn,
  output stageStrobe_t strobe,
  output logic         validOut
);
  always_comb begin
    strobe.capture = validIn && !rst;
  end

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= validIn;
  end
endmodule

// File: rtl/quad_clamp_dp.sv
module quad_clamp_dp
  import quad_clamp_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int NPIX  = 8
) (
  input  logic                  clk,
  input  stageStrobe_t          strobe,
  input  logic [PIX_W*NPIX-1:0] pixIn,
  output logic [PIX_W*NPIX-1:0] blkOut
);
  localparam int SHIFT  = $clog2(NPIX);
  localparam int SUM_W  = PIX_W + SHIFT;
  localparam int QUART  = 1 << (PIX_W - 2);
  localparam int NARROW = QUART / 2;
  localparam int WIDE   = QUART;

  logic [SUM_W-1:0] pixSum;
  logic [PIX_W-1:0] pixMin, pixMax, avgVal, spread;
  logic [1:0]       quarter;
  logic             narrowOk;
  bandSel_e         band;
  logic [PIX_W-1:0] loBound, hiBound;
  logic [PIX_W*NPIX-1:0] clamped;

  always_comb begin
    pixSum = '0;
    pixMin = pixIn[PIX_W-1:0];
    pixMax = pixIn[PIX_W-1:0];
    for (int i = 0; i < NPIX; i++) begin
      pixSum = pixSum + SUM_W'(pixIn[i*PIX_W +: PIX_W]);
      if (pixIn[i*PIX_W +: PIX_W] < pixMin) pixMin = pixIn[i*PIX_W +: PIX_W];
      if (pixIn[i*PIX_W +: PIX_W] > pixMax) pixMax = pixIn[i*PIX_W +: PIX_W];
    end
    avgVal  = PIX_W'(pixSum >> SHIFT);
    spread  = pixMax - pixMin;
    quarter = avgVal[PIX_W-1 -: 2];
    if (quarter == 2'd0 || quarter == 2'd3)
      narrowOk = 32'(spread) < NARROW;
    else
      narrowOk = 32'(spread) < WIDE;
    band    = narrowOk ? bandSel_e'({1'b0, quarter}) : BAND_PASS;
    loBound = {quarter, {(PIX_W-2){1'b0}}};
    hiBound = {quarter, {(PIX_W-2){1'b1}}};
  end

  for (genvar g = 0; g < NPIX; g++) begin : g_lane
    logic [PIX_W-1:0] sample;
    assign sample = pixIn[g*PIX_W +: PIX_W];
    always_comb begin
      if (band == BAND_PASS)      clamped[g*PIX_W +: PIX_W] = sample;
      else if (sample < loBound)  clamped[g*PIX_W +: PIX_W] = loBound;
      else if (sample > hiBound)  clamped[g*PIX_W +: PIX_W] = hiBound;
      else                        clamped[g*PIX_W +: PIX_W] = sample;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.capture) blkOut <= clamped;
  end
endmodule

// File: rtl/quad_clamp_stage.sv
module quad_clamp_stage
  import quad_clamp_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int NPIX  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  validIn,
  input  logic [PIX_W*NPIX-1:0] pixIn,
  output logic                  validOut,
  output logic [PIX_W*NPIX-1:0] blkOut
);
  stageStrobe_t strobe;

  quad_clamp_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .validIn  (validIn),
    .strobe   (strobe),
    .validOut (validOut)
  );

  quad_clamp_dp #(.PIX_W(PIX_W), .NPIX(NPIX)) u_dp (
    .clk    (clk),
    .strobe (strobe),
    .pixIn  (pixIn),
    .blkOut (blkOut)
  );
endmodule

// File: rtl/quad_clamp_chk.sv
module quad_clamp_chk #(
  parameter int PIX_W = 8,
  parameter int NPIX  = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  validIn,
  input logic [PIX_W*NPIX-1:0] pixIn,
  input logic                  validOut,
  input logic [PIX_W*NPIX-1:0] blkOut
);
  logic sameQuarter;
  always_comb begin
    sameQuarter = 1'b1;
    for (int i = 1; i < NPIX; i++)
      if (pixIn[i*PIX_W+PIX_W-1 -: 2] != pixIn[PIX_W-1 -: 2]) sameQuarter = 1'b0;
  end

  assert_reset_clears_valid_R2: assert property (@(posedge clk) rst |=> !validOut);

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
    validIn |=> validOut);

  assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> !validOut);

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> $stable(blkOut));

  // R8: a tile already inside one quarter can never be altered
  assert_in_quarter_untouched_R8: assert property (@(posedge clk) disable iff (rst)
    (validIn && sameQuarter) |=> (blkOut == $past(pixIn)));

  // R4 R5 R6 R7: a changed sample always lands on a quarter edge
  for (genvar g = 0; g < NPIX; g++) begin : g_edge
    assert_clamp_to_edge_R4: assert property (@(posedge clk) disable iff (rst)
      validIn |=> ((blkOut[g*PIX_W +: PIX_W] == $past(pixIn[g*PIX_W +: PIX_W])) ||
                   (blkOut[g*PIX_W +: PIX_W-2] == '0) ||
                   (blkOut[g*PIX_W +: PIX_W-2] == '1)));
  end
endmodule

bind quad_clamp_stage quad_clamp_chk #(.PIX_W(PIX_W), .NPIX(NPIX)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .validIn  (validIn),
  .pixIn    (pixIn),
  .validOut (validOut),
  .blkOut   (blkOut)
);

// File: tb/quad_clamp_stage_tb.sv
module quad_clamp_stage_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  typedef struct packed {
    logic [23:0] tag;
    logic [63:0] stim;
    logic [63:0] expect_;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{"R4 ", 64'h463C3C3C3C3C3C3C, 64'h3F3C3C3C3C3C3C3C},
    '{"R5 ", 64'h646464646464643E, 64'h6464646464646440},
    '{"R5 ", 64'h8264646464646464, 64'h7F64646464646464},
    '{"R6 ", 64'h969696967D969696, 64'h9696969680969696},
    '{"R6 ", 64'hAAAAC8AAAAAAAAAA, 64'hAAAABFAAAAAAAAAA},
    '{"R7 ", 64'hDCDCDCDCDCDCBEDC, 64'hDCDCDCDCDCDCC0DC},
    '{"R8 ", 64'h5232323232323232, 64'h5232323232323232},
    '{"R4 ", 64'h5132323232323232, 64'h3F32323232323232},
    '{"R8 ", 64'h7F7F7F7F7F7F7F3F, 64'h7F7F7F7F7F7F7F3F},
    '{"R5 ", 64'h7E7E7E7E7E7E7E3F, 64'h7E7E7E7E7E7E7E40},
    '{"R8 ", 64'hDFDFDFDFDFBFDFDF, 64'hDFDFDFDFDFBFDFDF},
    '{"R3 ", 64'h5132323246464646, 64'h3F3232323F3F3F3F},
    '{"R3 ", 64'h5232323246464646, 64'h5240404046464646}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        validIn = 1'b0;
  logic [63:0] pixIn = '0;
  logic        validOut;
  logic [63:0] blkOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_clamp_stage u_dut (
    .clk(clk), .rst(rst), .validIn(validIn), .pixIn(pixIn),
    .validOut(validOut), .blkOut(blkOut)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset valid", 64'(validOut), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle valid", 64'(validOut), 64'd0);

    // table walk, one tile per cycle (R10, R1)
    validIn = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      pixIn = VECS[i].stim;
      @(negedge clk);
      check($sformatf("%s vec%0d", VECS[i].tag, i), blkOut, VECS[i].expect_);
      check($sformatf("R10 valid vec%0d", i), 64'(validOut), 64'd1);
    end

    // R9: input ignored while idle
    validIn = 1'b0;
    pixIn = 64'h0011223344556677;
    @(negedge clk);
    check("R9 hold data", blkOut, VECS[NVEC-1].expect_);
    check("R1 valid drop", 64'(validOut), 64'd0);
    pixIn = 64'hFFEEDDCCBBAA9988;
    @(negedge clk);
    check("R9 hold data", blkOut, VECS[NVEC-1].expect_);

    // R8: full-range spread passes through
    validIn = 1'b1;
    pixIn = 64'hFF00FF00FF00FF00;
    @(negedge clk);
    check("R8 wide spread", blkOut, 64'hFF00FF00FF00FF00);

    // R2: reset during traffic
    rst = 1'b1;
    @(negedge clk);
    check("R2 reset mid-run", 64'(validOut), 64'd0);
    rst = 1'b0;
    validIn = 1'b0;
    @(negedge clk);
    check("R2 after reset", 64'(validOut), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule